// File: doc/BRIEF.md
# SPI FPGA Configuration Sequencer

This block loads a bitstream into an FPGA that accepts its configuration through a slave SPI port. After a start pulse it takes the SPI bus through a fixed command sequence. It reads the target's 32-bit identity and compares it with a built-in list of accepted devices. It refreshes the device, enables writes and clears the configuration memory. It then polls the status word until the device reports a clean memory, with a bounded number of timed polls.

Once the memory is clear, the bitstream is streamed from an 8-bit valid/ready input. The stream goes out inside one chip-select frame that opens with a write-increment header. A write-disable frame follows, and a final status read decides the outcome. The block reports the result on `done_ok` and a 2-bit error code, and `busy` is high for the whole run.

The SPI master uses mode 0 and shifts MSB first. Its serial clock is the system clock divided by a parameter. The poll interval is a cycle count derived from the clock frequency, and a bench can override it.

Top module: `fpga_cfg_seq`

## Requirements
- R1: During and after a synchronous active-low reset, `busy`, `done_ok` and `err_code` are 0, `bs_ready` is 0, `spi_cs_n` is 1 and `spi_sclk` is 0.
- R2: SPI runs in mode 0, MSB first. `spi_sclk` is low whenever `spi_cs_n` is high. Each command occupies exactly one low period of `spi_cs_n`, and `spi_cs_n` goes high between frames.
- R3: The identity read is one 8-byte frame: opcode 0x07, three 0x00 bytes, then four response bytes that form the ID, most significant byte first.
- R4: The IDs 0xC2088080 and 0xC2048080 are accepted. Any other ID ends the run after the ID frame with `err_code` = 1 and no further frame.
- R5: After an accepted ID come, in this order, a status read (0x09, three 0x00, four response bytes), then the 4-byte frames 0x71, 0x4A and 0x70, each followed by three 0x00 bytes.
- R6: After 0x70, status reads repeat. The run proceeds only when the status word equals exactly 0x00010000. Between the end of a failed poll frame and the start of the next, the gap is `POLL_CYCLES` plus a fixed overhead of at most 6 cycles.
- R7: If `MAX_POLLS` status polls all fail, the run ends with `err_code` = 2 and no further frame.
- R8: The bitstream frame is 0x41, 0xFF, 0xFF, 0xFF, then every accepted input byte up to and including the one with `bs_last`. While `bs_valid` is low during that phase, `spi_cs_n` stays low and `spi_sclk` stays low.
- R9: After the bitstream frame come a 0x4F frame with three 0x00 bytes and a final status read. If bit 14 (mask 0x00004000) of the final status is set, `done_ok` = 1 and `err_code` = 0. Otherwise `done_ok` = 0 and `err_code` = 3.
- R10: `start` is acted on only while `busy` is low. A pulse during a run neither restarts nor repeats the sequence.
- R11: `bs_ready` is high only in the data phase of the bitstream frame, while the SPI shifter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a configuration run |
| busy | output | 1 | High from the cycle after an accepted start until the result is posted |
| done_ok | output | 1 | Run finished with DONE set |
| err_code | output | 2 | 0 none, 1 unsupported ID, 2 clear timeout, 3 DONE not set |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_sclk | output | 1 | SPI serial clock, idle low |
| spi_mosi | output | 1 | SPI data to the target |
| spi_miso | input | 1 | SPI data from the target |
| bs_data | input | 8 | Bitstream byte |
| bs_valid | input | 1 | Bitstream byte is valid |
| bs_last | input | 1 | Marks the final bitstream byte |
| bs_ready | output | 1 | Sequencer takes `bs_data` on this cycle when `bs_valid` is high |

## Verification
`busy` rises one cycle after an accepted start. `err_code` and `done_ok` change in the same edge that drops `busy`, one cycle after chip select is released at the end of the last frame. The bench therefore waits for `busy` to fall, sampling only on falling clock edges, and reads the result there. A target model in the bench captures MOSI on each rising serial-clock edge and changes MISO only after such an edge, so the master always samples settled data. The model times the poll gap from the chip-select rise to the next fall. Under the bench parameters the expected gap is `POLL_CYCLES` + 4 clocks (release, re-arm, timer start, expiry, reopen), and the check accepts a small window around it.

// File: rtl/cfg_seq_pkg.sv
// Shared opcodes, status masks, accepted IDs and state encodings for the
// configuration sequencer. Assumes a slave port that takes 32-bit words
// most significant byte first.
package cfg_seq_pkg;
    localparam logic [7:0] OP_READ_ID   = 8'h07;
    localparam logic [7:0] OP_READ_STAT = 8'h09;
    localparam logic [7:0] OP_ERASE     = 8'h70;
    localparam logic [7:0] OP_REFRESH   = 8'h71;
    localparam logic [7:0] OP_WR_EN     = 8'h4A;
    localparam logic [7:0] OP_WR_DIS    = 8'h4F;
    localparam logic [7:0] OP_WR_INC    = 8'h41;

    localparam int          NUM_IDS = 2;
    localparam logic [31:0] ACCEPT_IDS [NUM_IDS] = '{32'hC208_8080, 32'hC204_8080};

    localparam logic [31:0] STAT_ERASED   = 32'h0001_0000;
    localparam logic [31:0] STAT_DONE_BIT = 32'h0000_4000;

    typedef enum logic [1:0] {
        ERR_NONE, ERR_BAD_ID, ERR_CLR_TMO, ERR_NOT_DONE
    } err_e;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_ID, S_CHK_ID, S_RD_STAT0, S_REFRESH, S_WR_EN,
        S_ERASE, S_POLL, S_POLL_WAIT, S_STREAM, S_WR_DIS, S_FINAL
    } seq_e;

    typedef enum logic [1:0] {PH_OPEN, PH_BYTE, PH_WAIT, PH_CLOSE} ph_e;
endpackage

// File: rtl/spi_byte_master.sv
// Mode-0 byte shifter. It moves one byte MSB first per start pulse and
// samples MISO on the rising edge of sclk. The sclk half period is HALF_DIV
// system clocks. Assumes start arrives only while busy is low; chip select
// is owned by the caller.
module spi_byte_master #(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [DW-1:0] div_cnt;
    logic [2:0]    bit_idx;
    logic [7:0]    shreg;
    logic          active;

    // Shift engine: divide the clock, toggle sclk, sample on rise, shift on fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            active  <= 1'b0;
            sclk    <= 1'b0;
            done    <= 1'b0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active  <= 1'b1;
                    shreg   <= tx_byte;
                    bit_idx <= '0;
                    div_cnt <= '0;
                    sclk    <= 1'b0;
                end
            end else if (div_cnt == DW'(HALF_DIV - 1)) begin
                div_cnt <= '0;
                if (!sclk) begin
                    sclk    <= 1'b1;
                    rx_byte <= {rx_byte[6:0], miso};
                end else begin
                    sclk    <= 1'b0;
                    shreg   <= {shreg[6:0], 1'b0};
                    bit_idx <= bit_idx + 3'd1;
                    if (bit_idx == 3'd7) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end
            end else begin
                div_cnt <= div_cnt + DW'(1);
            end
        end
    end

    assign busy = active;
    assign mosi = shreg[7];

    // R2
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> active);
endmodule

// File: rtl/poll_interval_timer.sv
// One-shot interval timer. An arm pulse starts it, and expired pulses for
// one cycle after POLL_CYCLES counts. Assumes POLL_CYCLES >= 1.
module poll_interval_timer #(
    parameter int POLL_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expired
);
    localparam int TW = $clog2(POLL_CYCLES + 1);

    logic [TW-1:0] cnt;
    logic          running;

    // Count the interval and raise a single expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (arm) begin
                running <= 1'b1;
                cnt     <= '0;
            end else if (running) begin
                if (cnt == TW'(POLL_CYCLES - 1)) begin
                    running <= 1'b0;
                    expired <= 1'b1;
                end else begin
                    cnt <= cnt + TW'(1);
                end
            end
        end
    end

    // R6
    expire_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired |-> $past(running));
endmodule

// File: rtl/fpga_cfg_seq.sv
// Configuration sequencer top. It runs ID read and check, refresh,
// write-enable, erase, a timed status poll, the bitstream frame,
// write-disable and a final status check. A single frame runner drives chip
// select and the byte shifter for every command. Assumes the target answers
// reads in bytes 4..7 of an 8-byte frame.
module fpga_cfg_seq
    import cfg_seq_pkg::*;
#(
    parameter int CLK_HZ      = 100_000_000,
    parameter int POLL_MS     = 10,
    parameter int POLL_CYCLES = CLK_HZ / 1000 * POLL_MS,
    parameter int MAX_POLLS   = 500,
    parameter int HALF_DIV    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic       busy,
    output logic       done_ok,
    output logic [1:0] err_code,
    output logic       spi_cs_n,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso,
    input  logic [7:0] bs_data,
    input  logic       bs_valid,
    input  logic       bs_last,
    output logic       bs_ready
);
    localparam int PW = $clog2(MAX_POLLS + 1);

    seq_e          seq;
    ph_e           ph;
    logic [2:0]    idx;
    logic [31:0]   word;
    logic          last_q;
    logic [PW-1:0] poll_cnt;
    logic          tmr_arm, tmr_exp;
    logic          spi_go, spi_busy, spi_done;
    logic [7:0]    spi_rx, tx_byte, cur_op;
    logic          rd_frm, strm, frame_end, id_ok;

    // Frame attributes for the current sequence step.
    always_comb begin
        cur_op = OP_READ_STAT;
        rd_frm = 1'b0;
        strm   = 1'b0;
        case (seq)
            S_RD_ID:                     begin cur_op = OP_READ_ID; rd_frm = 1'b1; end
            S_RD_STAT0, S_POLL, S_FINAL: begin cur_op = OP_READ_STAT; rd_frm = 1'b1; end
            S_REFRESH:                   cur_op = OP_REFRESH;
            S_WR_EN:                     cur_op = OP_WR_EN;
            S_ERASE:                     cur_op = OP_ERASE;
            S_STREAM:                    begin cur_op = OP_WR_INC; strm = 1'b1; end
            S_WR_DIS:                    cur_op = OP_WR_DIS;
            default:                     cur_op = OP_READ_STAT;
        endcase
    end

    // Byte to send: opcode, then stuffing, then payload or dummy.
    always_comb begin
        if (idx == 3'd0)      tx_byte = cur_op;
        else if (idx < 3'd4)  tx_byte = strm ? 8'hFF : 8'h00;
        else                  tx_byte = strm ? bs_data : 8'h00;
    end

    // Compare the captured ID against the accepted list.
    always_comb begin
        id_ok = 1'b0;
        for (int i = 0; i < NUM_IDS; i++)
            if (word == ACCEPT_IDS[i]) id_ok = 1'b1;
    end

    assign bs_ready  = (seq == S_STREAM) && (ph == PH_BYTE) && (idx == 3'd4);
    assign spi_go    = (ph == PH_BYTE) && (!bs_ready || bs_valid);
    assign frame_end = rd_frm ? (idx == 3'd7) :
                       strm   ? ((idx == 3'd4) && last_q) : (idx == 3'd3);

    // Sequencer and frame runner: step commands, track polls, post results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq      <= S_IDLE;
            ph       <= PH_CLOSE;
            idx      <= '0;
            word     <= '0;
            last_q   <= 1'b0;
            poll_cnt <= '0;
            tmr_arm  <= 1'b0;
            spi_cs_n <= 1'b1;
            busy     <= 1'b0;
            done_ok  <= 1'b0;
            err_code <= ERR_NONE;
        end else begin
            tmr_arm <= 1'b0;
            case (seq)
                S_IDLE: if (start) begin
                    busy     <= 1'b1;
                    done_ok  <= 1'b0;
                    err_code <= ERR_NONE;
                    poll_cnt <= '0;
                    seq      <= S_RD_ID;
                    ph       <= PH_OPEN;
                end
                S_CHK_ID: begin
                    if (id_ok) begin
                        seq <= S_RD_STAT0;
                        ph  <= PH_OPEN;
                    end else begin
                        err_code <= ERR_BAD_ID;
                        busy     <= 1'b0;
                        seq      <= S_IDLE;
                    end
                end
                S_POLL_WAIT: if (tmr_exp) begin
                    seq <= S_POLL;
                    ph  <= PH_OPEN;
                end
                default: begin
                    case (ph)
                        PH_OPEN: begin
                            spi_cs_n <= 1'b0;
                            idx      <= '0;
                            ph       <= PH_BYTE;
                        end
                        PH_BYTE: if (spi_go) begin
                            ph <= PH_WAIT;
                            if (bs_ready) last_q <= bs_last;
                        end
                        PH_WAIT: if (spi_done) begin
                            if (idx >= 3'd4) word <= {word[23:0], spi_rx};
                            if (frame_end) begin
                                spi_cs_n <= 1'b1;
                                ph       <= PH_CLOSE;
                            end else begin
                                idx <= (strm && idx == 3'd4) ? idx : idx + 3'd1;
                                ph  <= PH_BYTE;
                            end
                        end
                        PH_CLOSE: begin
                            case (seq)
                                S_RD_ID:    seq <= S_CHK_ID;
                                S_RD_STAT0: begin seq <= S_REFRESH; ph <= PH_OPEN; end
                                S_REFRESH:  begin seq <= S_WR_EN;   ph <= PH_OPEN; end
                                S_WR_EN:    begin seq <= S_ERASE;   ph <= PH_OPEN; end
                                S_ERASE:    begin seq <= S_POLL;    ph <= PH_OPEN; end
                                S_POLL: begin
                                    if (word == STAT_ERASED) begin
                                        seq <= S_STREAM;
                                        ph  <= PH_OPEN;
                                    end else if (poll_cnt == PW'(MAX_POLLS - 1)) begin
                                        err_code <= ERR_CLR_TMO;
                                        busy     <= 1'b0;
                                        seq      <= S_IDLE;
                                    end else begin
                                        poll_cnt <= poll_cnt + PW'(1);
                                        tmr_arm  <= 1'b1;
                                        seq      <= S_POLL_WAIT;
                                    end
                                end
                                S_STREAM:   begin seq <= S_WR_DIS; ph <= PH_OPEN; end
                                S_WR_DIS:   begin seq <= S_FINAL;  ph <= PH_OPEN; end
                                S_FINAL: begin
                                    if ((word & STAT_DONE_BIT) != 32'h0) done_ok <= 1'b1;
                                    else err_code <= ERR_NOT_DONE;
                                    busy <= 1'b0;
                                    seq  <= S_IDLE;
                                end
                                default: seq <= S_IDLE;
                            endcase
                        end
                        default: ph <= PH_CLOSE;
                    endcase
                end
            endcase
        end
    end

    spi_byte_master #(.HALF_DIV(HALF_DIV)) i_shift (
        .clk(clk), .rst_n(rst_n), .start(spi_go), .tx_byte(tx_byte),
        .busy(spi_busy), .done(spi_done), .rx_byte(spi_rx),
        .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
    );

    poll_interval_timer #(.POLL_CYCLES(POLL_CYCLES)) i_timer (
        .clk(clk), .rst_n(rst_n), .arm(tmr_arm), .expired(tmr_exp)
    );

    // R2
    cs_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);
    // R7
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt < PW'(MAX_POLLS));
    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bs_ready && !bs_valid) |=> (!spi_cs_n && !spi_sclk));
    // R9
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok |-> (err_code == ERR_NONE));
    // R10
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R11
    ready_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bs_ready |-> (!spi_cs_n && !spi_busy && busy));
endmodule

// File: tb/test_fpga_cfg_seq.sv
module test_fpga_cfg_seq;
    localparam int PC   = 40;
    localparam int MAXP = 6;

    typedef struct packed {
        logic [31:0] id;
        logic [7:0]  npoll;
        logic        dn;
        logic [7:0]  nbytes;
        logic [3:0]  gap;
        logic [1:0]  xerr;
        logic        xok;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'hC208_8080, 8'd0, 1'b1, 8'd5,  4'd0, 2'd0, 1'b1},
        '{32'hC204_8080, 8'd3, 1'b1, 8'd12, 4'd2, 2'd0, 1'b1},
        '{32'hC204_8080, 8'd2, 1'b0, 8'd3,  4'd0, 2'd3, 1'b0},
        '{32'hC208_8081, 8'd0, 1'b1, 8'd0,  4'd0, 2'd1, 1'b0},
        '{32'h8080_08C2, 8'd0, 1'b1, 8'd0,  4'd0, 2'd1, 1'b0},
        '{32'hC208_8080, 8'd5, 1'b1, 8'd1,  4'd1, 2'd0, 1'b1},
        '{32'hC208_8080, 8'd6, 1'b1, 8'd0,  4'd0, 2'd2, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic busy, done_ok, spi_cs_n, spi_sclk, spi_mosi, spi_miso;
    logic [1:0] err_code;
    logic [7:0] bs_data = 8'h00;
    logic bs_valid = 1'b0, bs_last = 1'b0, bs_ready;

    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    fpga_cfg_seq #(.POLL_CYCLES(PC), .MAX_POLLS(MAXP), .HALF_DIV(2)) i_fpga_cfg_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done_ok(done_ok),
        .err_code(err_code), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .bs_data(bs_data),
        .bs_valid(bs_valid), .bs_last(bs_last), .bs_ready(bs_ready)
    );

    // Target model state
    int bitcnt = 0, nframes = 0, sbytes = 0, ssum = 0, stuff_bad = 0, poll_idx = 0;
    int gapc [64];
    logic [7:0] ops [64];
    logic [7:0] rxsh = 0, cur_op = 0;
    logic [31:0] resp = 0, m_id = 0;
    int m_np = 0;
    bit m_done = 0, clr_seen = 0, streamed = 0, in_frame = 0;
    time t_rise = 0;
    int sclk_bad = 0;

    assign spi_miso = (in_frame && bitcnt >= 32 && bitcnt < 64 &&
                       (cur_op == 8'h07 || cur_op == 8'h09)) ? resp[31 - (bitcnt - 32)] : 1'b0;

    task automatic model_clear();
        nframes = 0; sbytes = 0; ssum = 0; stuff_bad = 0; poll_idx = 0;
        clr_seen = 0; streamed = 0;
    endtask

    always @(negedge spi_cs_n) begin
        in_frame = 1; bitcnt = 0;
        if (nframes < 64) gapc[nframes] = int'((($time - t_rise)) / 4);
    end

    always @(posedge spi_cs_n) if (in_frame) begin
        in_frame = 0;
        if (nframes < 64) ops[nframes] = cur_op;
        nframes++;
        if (cur_op == 8'h70) clr_seen = 1;
        if (cur_op == 8'h41) streamed = 1;
        if (cur_op == 8'h09 && clr_seen && !streamed) poll_idx++;
        t_rise = $time;
    end

    always @(posedge spi_sclk) begin
        if (spi_cs_n) sclk_bad++;
        else begin
            logic [7:0] b;
            int k;
            b = {rxsh[6:0], spi_mosi};
            rxsh = b;
            bitcnt++;
            if (bitcnt % 8 == 0) begin
                k = bitcnt / 8 - 1;
                if (k == 0) begin
                    cur_op = b;
                    if (b == 8'h07) resp = m_id;
                    else if (streamed) resp = m_done ? 32'h0001_4000 : 32'h0001_0000;
                    else if (clr_seen) resp = (poll_idx < m_np) ? 32'h0001_0001 : 32'h0001_0000;
                    else resp = 32'h0;
                end else if (k < 4) begin
                    if (cur_op == 8'h41) begin if (b != 8'hFF) stuff_bad++; end
                    else if (b != 8'h00) stuff_bad++;
                end else if (cur_op == 8'h41) begin
                    sbytes++; ssum += b;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] bs_byte(input int seed, input int k);
        return 8'((seed + k * 29) & 8'hFF);
    endfunction

    function automatic logic [7:0] exp_op(input vec_t v, input int k);
        int np;
        np = (v.xerr == 2'd2) ? MAXP : int'(v.npoll) + 1;
        case (k)
            0: return 8'h07; 1: return 8'h09; 2: return 8'h71; 3: return 8'h4A; 4: return 8'h70;
            default: begin
                if (k < 5 + np) return 8'h09;
                if (k == 5 + np) return 8'h41;
                if (k == 6 + np) return 8'h4F;
                return 8'h09;
            end
        endcase
    endfunction

    task automatic send_stream(input int n, input int gap, input int seed);
        for (int k = 0; k < n; k++) begin
            for (int g = 0; g < gap; g++) @(negedge clk);
            bs_data = bs_byte(seed, k); bs_last = (k == n - 1); bs_valid = 1'b1;
            @(negedge clk);
            while (!bs_ready) @(negedge clk);
            @(negedge clk);
            bs_valid = 1'b0; bs_last = 1'b0;
        end
    endtask

    task automatic wait_idle(output bit ok);
        int n;
        n = 0; ok = 1;
        @(negedge clk);
        while (busy && n < 30000) begin @(negedge clk); n++; end
        if (busy) ok = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    initial begin
        bit ok;
        int exp_sum, nf, bad;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "busy", busy, 0); chk("R1", "done_ok", done_ok, 0);
        chk("R1", "err", err_code, 0); chk("R1", "cs_n", spi_cs_n, 1);
        chk("R1", "sclk", spi_sclk, 0); chk("R1", "ready", bs_ready, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            model_clear(); m_id = v.id; m_np = int'(v.npoll); m_done = v.dn;
            pulse_start();
            chk("R10", "busy after start", busy, 1);
            fork
                begin if (v.nbytes != 0) send_stream(int'(v.nbytes), int'(v.gap), i * 7); end
                begin wait_idle(ok); end
            join
            chk("R2", "run finished", ok, 1);
            // R4 R7 R9: result codes
            chk(v.xerr == 2'd1 ? "R4" : v.xerr == 2'd2 ? "R7" : "R9", "err_code", err_code, v.xerr);
            chk("R9", "done_ok", done_ok, v.xok);
            nf = (v.xerr == 2'd1) ? 1 : (v.xerr == 2'd2) ? 5 + MAXP : 9 + int'(v.npoll);
            chk(v.xerr == 2'd1 ? "R4" : "R7", "frame count", nframes, nf);
            bad = 0;
            for (int k = 0; k < nframes && k < 64; k++) if (ops[k] !== exp_op(v, k)) bad++;
            chk("R5", "opcode order", bad, 0);
            chk("R3", "stuffing/header bytes", stuff_bad, 0);
            exp_sum = 0;
            for (int k = 0; k < int'(v.nbytes); k++) exp_sum += int'(bs_byte(i * 7, k));
            chk("R8", "stream byte count", sbytes, (v.xerr == 2'd0 || v.xerr == 2'd3) ? int'(v.nbytes) : 0);
            chk("R8", "stream sum", ssum, (v.xerr == 2'd0 || v.xerr == 2'd3) ? exp_sum : 0);
            if (v.npoll >= 2) begin
                // R6: gap before second poll frame (index 6)
                checks++;
                if (gapc[6] < PC || gapc[6] > PC + 6) begin
                    fails++;
                    $display("FAIL R6 poll gap: actual %0d expected %0d..%0d", gapc[6], PC, PC + 6);
                end
            end
            repeat (3) @(negedge clk);
        end

        // R10: start pulse during a run is ignored
        model_clear(); m_id = 32'hC204_8080; m_np = 1; m_done = 1;
        pulse_start();
        repeat (50) @(negedge clk);
        pulse_start();
        fork
            begin send_stream(2, 0, 3); end
            begin wait_idle(ok); end
        join
        repeat (20) @(negedge clk);
        chk("R10", "busy stays low", busy, 0);
        chk("R10", "single sequence", nframes, 10);
        chk("R9", "done_ok", done_ok, 1);

        // R2: serial clock never pulsed with chip select high
        chk("R2", "sclk while cs high", sclk_bad, 0);

        // R1: reset in the middle of the poll loop
        model_clear(); m_np = 5;
        pulse_start();
        repeat (400) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "busy mid reset", busy, 0);
        chk("R1", "cs_n mid reset", spi_cs_n, 1);
        chk("R11", "ready mid reset", bs_ready, 0);
        chk("R1", "err mid reset", err_code, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule